// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block drives an external 10-bit analog-to-digital converter that sits behind an eight-input channel multiplexer. It keeps track of the selected channel. Whenever the selection moves, it enforces a programmable settling wait, counted in clock cycles. It then runs a start/valid handshake with the converter and returns the sample in a 16-bit result word.

A conversion can be requested in two ways. The first is a software write to a GO control bit. The second is a timer compare event, and this path works only while the hardware auto-start enable is set. GO reads as busy from the request until the sample is captured. The captured sample is placed either in the low ten bits or in the high ten bits of the result word, and the unused bits are filled with zeros. When a conversion completes, the block issues a one-cycle completion pulse and sets a sticky interrupt flag. The upper and lower reference choices are configuration bits that the block only registers and forwards to the analog side.

Top module: `adc_sequencer`

## Requirements
- R1: After reset, go_busy, cnv_start, done_pulse and irq_flag are 0 and result is 16'h0000.
- R2: A conversion request is a go_set pulse, or a cmp_event pulse while auto_start_en is 1. A cmp_event while auto_start_en is 0 starts nothing and leaves go_busy at 0.
- R3: When chan_sel changes, the acquisition count reloads from acq_cycles. A request sampled at the same edge as the change asserts cnv_start on the (acq_cycles+1)-th clock edge after that edge. Another channel change during the count restarts the count from that later edge.
- R4: go_busy is 1 from the edge that samples a request until the edge that captures cnv_valid, and is 0 after that edge.
- R5: cnv_start is a single-cycle pulse. cnv_chan holds the channel captured at launch for the whole conversion, even if chan_sel changes.
- R6: At the edge where cnv_valid is sampled, result becomes {6'b0, cnv_data} when left_just is 0, or {cnv_data, 6'b0} when left_just is 1.
- R7: done_pulse is high for exactly one cycle, in the cycle after the capture edge. irq_flag is set at that same edge and stays set until irq_clr is sampled high. If a set and a clear arrive together, the set wins.
- R8: A request that arrives while a conversion is waiting or running is ignored. One GO yields exactly one cnv_start.
- R9: vref_sel equals ref_cfg delayed by one clock. Bit 1 selects the upper reference and bit 0 the lower reference; a 1 means the external pin.
- R10: If the channel has not changed and its acquisition count has expired, cnv_start is asserted by the same edge that samples the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_sel | input | 3 | Selected analog channel |
| acq_cycles | input | 8 | Acquisition wait in clock cycles |
| left_just | input | 1 | 1 places the sample in the top bits of result |
| go_set | input | 1 | Software GO write pulse |
| cmp_event | input | 1 | Timer compare event pulse |
| auto_start_en | input | 1 | Allows cmp_event to start a conversion |
| ref_cfg | input | 2 | Reference selection (bit 1 upper, bit 0 lower) |
| irq_clr | input | 1 | Clears the interrupt flag |
| cnv_valid | input | 1 | Converter sample valid |
| cnv_data | input | 10 | Converter sample |
| cnv_start | output | 1 | Converter start pulse |
| cnv_chan | output | 3 | Channel presented to the converter |
| vref_sel | output | 2 | Registered reference selection |
| go_busy | output | 1 | GO bit read value |
| result | output | 16 | Justified result word |
| done_pulse | output | 1 | One-cycle completion pulse |
| irq_flag | output | 1 | Sticky completion interrupt |

## Verification
Every result appears at a known distance from its stimulus, counted in edges:
- With a settled channel, cnv_start rises one edge after the request.
- After a channel change sampled together with the request, cnv_start rises acq_cycles+2 edges after the request edge.
- result, go_busy and irq_flag change at the edge that samples cnv_valid, and done_pulse drops one edge later.
- vref_sel follows ref_cfg one edge later.

Inputs are driven on falling edges. The bench counts falling edges from the request and compares the count at which cnv_start is first seen against the figure taken from the requirement. The bench's converter model answers a fixed number of edges after each start pulse.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_WAIT = 2'd1,
        S_CONV = 2'd2
    } seq_state_e;
endpackage

// File: rtl/adc_acq_timer.sv
module adc_acq_timer #(
    parameter int N_CH  = 8,
    parameter int ACQ_W = 8,
    localparam int CH_W = $clog2(N_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CH_W-1:0]  chan_sel,
    input  logic [ACQ_W-1:0] acq_cycles,
    output logic [CH_W-1:0]  chan_q,
    output logic             ready
);
    typedef struct packed {
        logic [CH_W-1:0]  ch;
        logic [ACQ_W-1:0] cnt;
    } acq_t;

    acq_t acq_q, acq_d;

    always_comb begin
        acq_d = acq_q;
        if (chan_sel != acq_q.ch) begin
            acq_d.ch  = chan_sel;
            acq_d.cnt = acq_cycles;
        end else if (acq_q.cnt != '0) begin
            acq_d.cnt = acq_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acq_q <= '0;
        else        acq_q <= acq_d;
    end

    assign chan_q = acq_q.ch;
    assign ready  = (acq_q.cnt == '0) && (chan_sel == acq_q.ch);

    // R3: a channel change with a nonzero wait blocks readiness next cycle
    p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_sel != chan_q && acq_cycles != '0) |=> !ready);

    // R10: once settled, readiness holds while the channel stays put
    p_ready_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $stable(chan_sel)) |=> (ready || chan_sel != chan_q));
endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt #(
    parameter int ADC_W = 10,
    parameter int RES_W = 16
) (
    input  logic [ADC_W-1:0] raw,
    input  logic             left,
    output logic [RES_W-1:0] word
);
    localparam int PAD = RES_W - ADC_W;

    generate
        if (PAD == 0) begin : g_full
            assign word = raw;
            logic unused_left;
            assign unused_left = left;
        end else begin : g_pad
            assign word = left ? {raw, {PAD{1'b0}}} : {{PAD{1'b0}}, raw};
        end
    endgenerate
endmodule

// File: rtl/adc_sequencer.sv
module adc_sequencer
    import adc_seq_pkg::*;
#(
    parameter int N_CH  = 8,
    parameter int ADC_W = 10,
    parameter int RES_W = 16,
    parameter int ACQ_W = 8,
    localparam int CH_W = $clog2(N_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CH_W-1:0]  chan_sel,
    input  logic [ACQ_W-1:0] acq_cycles,
    input  logic             left_just,
    input  logic             go_set,
    input  logic             cmp_event,
    input  logic             auto_start_en,
    input  logic [1:0]       ref_cfg,
    input  logic             irq_clr,
    input  logic             cnv_valid,
    input  logic [ADC_W-1:0] cnv_data,
    output logic             cnv_start,
    output logic [CH_W-1:0]  cnv_chan,
    output logic [1:0]       vref_sel,
    output logic             go_busy,
    output logic [RES_W-1:0] result,
    output logic             done_pulse,
    output logic             irq_flag
);
    localparam int PAD = RES_W - ADC_W;

    typedef struct packed {
        seq_state_e       st;
        logic             go;
        logic             start;
        logic [CH_W-1:0]  ch;
        logic [RES_W-1:0] res;
        logic             done;
        logic             irq;
        logic [1:0]       vref;
    } seq_t;

    seq_t seq_q, seq_d;

    logic [CH_W-1:0]  chan_q;
    logic             acq_ready;
    logic [RES_W-1:0] fmt_word;
    logic             start_req;

    adc_acq_timer #(.N_CH(N_CH), .ACQ_W(ACQ_W)) u_acq (
        .clk       (clk),
        .rst_n     (rst_n),
        .chan_sel  (chan_sel),
        .acq_cycles(acq_cycles),
        .chan_q    (chan_q),
        .ready     (acq_ready)
    );

    adc_result_fmt #(.ADC_W(ADC_W), .RES_W(RES_W)) u_fmt (
        .raw (cnv_data),
        .left(left_just),
        .word(fmt_word)
    );

    assign start_req = go_set | (cmp_event & auto_start_en);

    always_comb begin
        seq_d       = seq_q;
        seq_d.start = 1'b0;
        seq_d.done  = 1'b0;
        seq_d.vref  = ref_cfg;
        if (irq_clr) seq_d.irq = 1'b0;
        unique case (seq_q.st)
            S_IDLE: begin
                if (start_req) begin
                    seq_d.go = 1'b1;
                    if (acq_ready) begin
                        seq_d.start = 1'b1;
                        seq_d.ch    = chan_q;
                        seq_d.st    = S_CONV;
                    end else begin
                        seq_d.st = S_WAIT;
                    end
                end
            end
            S_WAIT: begin
                if (acq_ready) begin
                    seq_d.start = 1'b1;
                    seq_d.ch    = chan_q;
                    seq_d.st    = S_CONV;
                end
            end
            S_CONV: begin
                if (cnv_valid) begin
                    seq_d.res  = fmt_word;
                    seq_d.go   = 1'b0;
                    seq_d.done = 1'b1;
                    seq_d.irq  = 1'b1;
                    seq_d.st   = S_IDLE;
                end
            end
            default: seq_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '{st: S_IDLE, default: '0};
        else        seq_q <= seq_d;
    end

    assign cnv_start  = seq_q.start;
    assign cnv_chan   = seq_q.ch;
    assign vref_sel   = seq_q.vref;
    assign go_busy    = seq_q.go;
    assign result     = seq_q.res;
    assign done_pulse = seq_q.done;
    assign irq_flag   = seq_q.irq;

    // R3: a launch only follows a settled acquisition
    p_launch_settled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv_start) |-> $past(acq_ready));

    // R5: start is one cycle wide
    p_start_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_start |=> !cnv_start);

    // R5: channel held while converting
    p_chan_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (go_busy && !cnv_start && !done_pulse) |-> $stable(cnv_chan));

    // R4: GO stays set until the sample arrives
    p_go_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (go_busy && !cnv_valid) |=> go_busy);

    // R4: GO only clears together with completion
    p_go_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(go_busy) |-> done_pulse);

    // R7: completion pulse is one cycle wide
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

    // R7: interrupt flag is sticky
    p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag);

    // R6: one side of the result word is zero filled
    p_zero_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> ((result[RES_W-1:ADC_W] == '0) || (result[PAD-1:0] == '0)));
endmodule

// File: tb/adc_sequencer_bench.sv
module adc_sequencer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  chan_sel = '0;
    logic [7:0]  acq_cycles = '0;
    logic        left_just = 1'b0;
    logic        go_set = 1'b0;
    logic        cmp_event = 1'b0;
    logic        auto_start_en = 1'b0;
    logic [1:0]  ref_cfg = '0;
    logic        irq_clr = 1'b0;
    logic        cnv_valid;
    logic [9:0]  mdl_data = '0;
    logic        cnv_start;
    logic [2:0]  cnv_chan;
    logic [1:0]  vref_sel;
    logic        go_busy;
    logic [15:0] result;
    logic        done_pulse;
    logic        irq_flag;

    int checks = 0;
    int fails  = 0;
    int start_cnt = 0;
    logic [2:0] mdl_cnt;

    always #5 clk = ~clk;

    adc_sequencer u_adc_sequencer (
        .clk(clk), .rst_n(rst_n), .chan_sel(chan_sel), .acq_cycles(acq_cycles),
        .left_just(left_just), .go_set(go_set), .cmp_event(cmp_event),
        .auto_start_en(auto_start_en), .ref_cfg(ref_cfg), .irq_clr(irq_clr),
        .cnv_valid(cnv_valid), .cnv_data(mdl_data), .cnv_start(cnv_start),
        .cnv_chan(cnv_chan), .vref_sel(vref_sel), .go_busy(go_busy),
        .result(result), .done_pulse(done_pulse), .irq_flag(irq_flag)
    );

    // converter model: valid three edges after the start pulse is seen
    always @(posedge clk) begin
        if (!rst_n) begin
            mdl_cnt   <= '0;
            cnv_valid <= 1'b0;
            start_cnt <= 0;
        end else begin
            cnv_valid <= (mdl_cnt == 3'd1);
            if (cnv_start) begin
                mdl_cnt   <= 3'd3;
                start_cnt <= start_cnt + 1;
            end else if (mdl_cnt != 0) begin
                mdl_cnt <= mdl_cnt - 1'b1;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_done(output bit busy_ok);
        busy_ok = 1'b1;
        for (int n = 0; n < 100 && !done_pulse; n++) begin
            if (!go_busy) busy_ok = 1'b0;
            @(negedge clk);
        end
    endtask

    typedef struct packed {
        logic [2:0]  ch;
        logic        lj;
        logic [9:0]  dat;
        logic [7:0]  acq;
        logic [7:0]  exp_k;
        logic [15:0] exp_res;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{3'd0, 1'b0, 10'h3FF, 8'd4, 8'd1,  16'h03FF},
        '{3'd3, 1'b0, 10'h155, 8'd4, 8'd6,  16'h0155},
        '{3'd3, 1'b1, 10'h155, 8'd4, 8'd1,  16'h5540},
        '{3'd7, 1'b1, 10'h201, 8'd0, 8'd2,  16'h8040},
        '{3'd2, 1'b0, 10'h000, 8'd9, 8'd11, 16'h0000},
        '{3'd2, 1'b1, 10'h3FF, 8'd9, 8'd1,  16'hFFC0}
    };

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int k;
        int s0;
        bit ok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 go_busy", go_busy, 0);
        chk("R1 cnv_start", cnv_start, 0);
        chk("R1 done", done_pulse, 0);
        chk("R1 irq", irq_flag, 0);
        chk("R1 result", result, 0);

        foreach (VEC[i]) begin
            chan_sel = VEC[i].ch; left_just = VEC[i].lj;
            acq_cycles = VEC[i].acq; mdl_data = VEC[i].dat;
            go_set = 1'b1;
            k = 0;
            do begin @(negedge clk); go_set = 1'b0; k++; end
            while (!cnv_start && k < 100);
            chk((VEC[i].exp_k == 1) ? "R10 latency" : "R3 latency", k, VEC[i].exp_k);
            wait_done(ok);
            chk("R4 busy while converting", ok, 1);
            chk("R6 result", result, VEC[i].exp_res);
            chk("R4 go cleared", go_busy, 0);
            chk("R7 irq set", irq_flag, 1);
            chk("R5 cnv_chan", cnv_chan, VEC[i].ch);
            @(negedge clk);
            chk("R7 done one cycle", done_pulse, 0);
            irq_clr = 1'b1;
            @(negedge clk);
            irq_clr = 1'b0;
            chk("R7 irq cleared", irq_flag, 0);
        end

        // R2: compare event without auto-start
        s0 = start_cnt;
        cmp_event = 1'b1; @(negedge clk); cmp_event = 1'b0;
        repeat (8) @(negedge clk);
        chk("R2 cmp ignored starts", start_cnt, s0);
        chk("R2 cmp ignored busy", go_busy, 0);

        // R2: compare event with auto-start, channel settled
        auto_start_en = 1'b1; mdl_data = 10'h0AA; left_just = 1'b0;
        cmp_event = 1'b1; @(negedge clk); cmp_event = 1'b0;
        chk("R2 cmp starts", cnv_start, 1);
        wait_done(ok);
        chk("R2 cmp result", result, 16'h00AA);
        auto_start_en = 1'b0;
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;

        // R8: requests while waiting or converting are ignored
        s0 = start_cnt;
        chan_sel = 3'd5; acq_cycles = 8'd6; go_set = 1'b1;
        @(negedge clk); go_set = 1'b0;
        @(negedge clk); go_set = 1'b1;
        @(negedge clk); go_set = 1'b0; cmp_event = 1'b1; auto_start_en = 1'b1;
        @(negedge clk); cmp_event = 1'b0; auto_start_en = 1'b0;
        for (int n = 0; n < 50 && !cnv_start; n++) @(negedge clk);
        go_set = 1'b1; @(negedge clk); go_set = 1'b0;
        wait_done(ok);
        repeat (12) @(negedge clk);
        chk("R8 single start", start_cnt, s0 + 1);
        chk("R8 idle after", go_busy, 0);

        // R3: a second channel change restarts the count
        chan_sel = 3'd1; acq_cycles = 8'd5; go_set = 1'b1;
        k = 0;
        do begin
            @(negedge clk); go_set = 1'b0; k++;
            if (k == 3) chan_sel = 3'd6;
        end while (!cnv_start && k < 100);
        chk("R3 restart latency", k, 10);
        @(negedge clk);
        chan_sel = 3'd0;
        wait_done(ok);
        chk("R5 channel held", cnv_chan, 3'd6);
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;

        // R7: set wins over a simultaneous clear
        repeat (10) @(negedge clk);
        irq_clr = 1'b1; go_set = 1'b1;
        @(negedge clk); go_set = 1'b0;
        wait_done(ok);
        chk("R7 set beats clear", irq_flag, 1);
        @(negedge clk);
        chk("R7 clear after", irq_flag, 0);
        irq_clr = 1'b0;

        // R9: reference selection follows with one register
        ref_cfg = 2'b10; @(negedge clk);
        chk("R9 vref upper", vref_sel, 2'b10);
        ref_cfg = 2'b01; @(negedge clk);
        chk("R9 vref lower", vref_sel, 2'b01);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule